// File: doc/BRIEF.md
# Memory Pattern Self-Test Sequencer

This block runs a full self-test of an external word-addressed memory. It is launched from an active-low push-button. First it writes every location, from address zero upward, with words from a 32-bit pseudo-random generator that starts from a fixed seed. Then it reads every location back in the same order. Each returned word is compared with a second generator that is reseeded and stepped in step with the returning data. No copy of the written data is kept anywhere.

Memory requests leave the block as a valid/ready stream. `mem_we` or `mem_rd` is the valid. The memory raises `mem_ready` when it can take a request. While a request waits for `mem_ready`, the block holds the address, the data and the request kind unchanged. A request transfers on the rising clock edge where valid and `mem_ready` are both high. Read data comes back in request order, one word per cycle in which `mem_rvalid` is high, at whatever latency the memory has. The read-data path has no back-pressure: the block takes a word on every `mem_rvalid` cycle.

Three red status LEDs report progress:
- all three are lit while the button is held;
- two of them blink at a prescaled rate during the test;
- on success one stays steadily lit;
- on failure a different one stays steadily lit.

Top module: `mem_selftest_top`

## Requirements
- R1: After reset `led` is 3'b000 and neither `mem_we` nor `mem_rd` is asserted.
- R2: `start_n` passes through a two-flop synchronizer. While it is held low, `led` is 3'b111 and no request is issued, whatever the block was doing before. Pressing the button during a test aborts that test.
- R3: Releasing the button starts a pass. The write phase issues exactly 2^ADDR_W write requests, at addresses 0, 1, 2 and so on upward. The data sequence starts with `SEED` and then follows the rule next = (s >> 1) ^ (s[0] ? MASK : 0), with defaults SEED = 32'h5EED_0001 and MASK = 32'hA300_0000.
- R4: No read request is issued until the last write has transferred. Read requests then cover addresses 0 to 2^ADDR_W-1 in ascending order, each exactly once.
- R5: A write or read request that is not accepted (`mem_ready` low) stays asserted with the same address and write data until it is accepted. Nothing is transferred while `mem_ready` is low.
- R6: Read data is sampled only in read-phase cycles where `mem_rvalid` is high. The k-th returned word is compared with the k-th word of the R3 sequence, which is regenerated from `SEED`. A `mem_rvalid` pulse during the write phase has no effect on the result.
- R7: While a pass runs, `led[0]` is 0 and `led[2]` equals `led[1]`. Both toggle exactly every BLINK_DIV clock cycles, starting from off.
- R8: When all 2^ADDR_W words match, `led` becomes 3'b010 and stays there until the next button press.
- R9: Any mismatch sets a sticky fail flag. When the pass ends, `led` becomes 3'b100 and stays there, even if every later word matched.
- R10: A new pass clears the fail flag. A pass that follows a failed or aborted pass reports on its own data only.
- R11: `mem_we` and `mem_rd` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_n | input | 1 | Active-low start button, asynchronous |
| mem_ready | input | 1 | Memory accepts the presented request |
| mem_we | output | 1 | Write request valid |
| mem_rd | output | 1 | Read request valid |
| mem_addr | output | ADDR_W | Request word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Returned read word is valid this cycle |
| mem_rdata | input | DATA_W | Returned read word |
| led | output | 3 | Status LEDs: bit0/bit1/bit2 |

## Verification
The bench uses four kinds of pass, each aimed at a different error:
- A memory that is always ready gives the cleanest write and read ordering.
- A memory whose ready is drawn from a seeded random source checks that stalled requests are held. It also checks that the write generator advances only on real transfers.
- Directed passes corrupt one word on read-back, first the last address and then address zero. They show whether a mismatch is both detected and kept until the end of the pass.
- A further pass injects stray read-valid pulses during the write phase, an abort presses the button mid-pass, and a long ready-low stall checks that nothing moves while back-pressure is held.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HELD  = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_PASS  = 3'd4,
    ST_FAIL  = 3'd5
  } mst_state_e;

  localparam logic [2:0] LED_OFF  = 3'b000;
  localparam logic [2:0] LED_HELD = 3'b111;
  localparam logic [2:0] LED_PASS = 3'b010;
  localparam logic [2:0] LED_FAIL = 3'b100;

endpackage

// File: rtl/mst_key_sync.sv
module mst_key_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_n,
  output logic held
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= key_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign held = ~chain[STAGES-1];
endmodule

// File: rtl/mst_lfsr.sv
module mst_lfsr #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    SEED = 32'h5EED_0001,
  parameter logic [W-1:0]    MASK = 32'hA300_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] word
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = word >> 1;
    if (word[0]) nxt = nxt ^ MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    word <= SEED;
    else if (load) word <= SEED;
    else if (adv)  word <= nxt;
  end
endmodule

// File: rtl/mst_blink.sv
module mst_blink #(
  parameter int DIV = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == LAST) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mst_seq.sv
module mst_seq
  import mst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_held,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] gen_word,
  input  logic [DATA_W-1:0] chk_word,
  output logic              mem_we,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              gen_load,
  output logic              gen_adv,
  output logic              chk_load,
  output logic              chk_adv,
  output mst_state_e        state
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  logic [ADDR_W-1:0] waddr, raddr, rcnt;
  logic              rd_done, fail_q;
  logic              wr_fire, rd_fire, rsp_take, mismatch;

  always_comb begin
    mem_we    = (state == ST_WRITE);
    mem_rd    = (state == ST_READ) && !rd_done;
    mem_addr  = (state == ST_WRITE) ? waddr : ((state == ST_READ) ? raddr : '0);
    mem_wdata = mem_we ? gen_word : '0;
    wr_fire   = mem_we && mem_ready && !key_held;
    rd_fire   = mem_rd && mem_ready && !key_held;
    rsp_take  = (state == ST_READ) && mem_rvalid && !key_held;
    mismatch  = rsp_take && (mem_rdata != chk_word);
    gen_load  = (state == ST_HELD) && !key_held;
    gen_adv   = wr_fire;
    chk_load  = wr_fire && (waddr == LAST);
    chk_adv   = rsp_take;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      waddr   <= '0;
      raddr   <= '0;
      rcnt    <= '0;
      rd_done <= 1'b0;
      fail_q  <= 1'b0;
    end else if (key_held) begin
      state <= ST_HELD;
    end else begin
      unique case (state)
        ST_HELD: begin
          state  <= ST_WRITE;
          waddr  <= '0;
          fail_q <= 1'b0;
        end
        ST_WRITE: begin
          if (wr_fire) begin
            waddr <= waddr + 1'b1;
            if (waddr == LAST) begin
              state   <= ST_READ;
              raddr   <= '0;
              rcnt    <= '0;
              rd_done <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (rd_fire) begin
            raddr <= raddr + 1'b1;
            if (raddr == LAST) rd_done <= 1'b1;
          end
          if (rsp_take) begin
            rcnt <= rcnt + 1'b1;
            if (mismatch) fail_q <= 1'b1;
            if (rcnt == LAST) state <= (fail_q || mismatch) ? ST_FAIL : ST_PASS;
          end
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/mem_selftest_top.sv
module mem_selftest_top
  import mst_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] SEED      = 32'h5EED_0001,
  parameter logic [31:0] MASK      = 32'hA300_0000,
  parameter int          BLINK_DIV = 25_000_000,
  parameter int          SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [2:0]        led
);
  logic              key_held, gen_load, gen_adv, chk_load, chk_adv, blink;
  logic [DATA_W-1:0] gen_word, chk_word;
  mst_state_e        state;

  mst_key_sync #(.STAGES(SYNC_STG)) key_i (
    .clk(clk), .rst_n(rst_n), .key_n(start_n), .held(key_held)
  );

  mst_lfsr #(.W(DATA_W), .SEED(DATA_W'(SEED)), .MASK(DATA_W'(MASK))) gen_i (
    .clk(clk), .rst_n(rst_n), .load(gen_load), .adv(gen_adv), .word(gen_word)
  );

  mst_lfsr #(.W(DATA_W), .SEED(DATA_W'(SEED)), .MASK(DATA_W'(MASK))) chk_i (
    .clk(clk), .rst_n(rst_n), .load(chk_load), .adv(chk_adv), .word(chk_word)
  );

  mst_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .key_held(key_held),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .gen_word(gen_word), .chk_word(chk_word),
    .mem_we(mem_we), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .gen_load(gen_load), .gen_adv(gen_adv), .chk_load(chk_load), .chk_adv(chk_adv),
    .state(state)
  );

  mst_blink #(.DIV(BLINK_DIV)) blink_i (
    .clk(clk), .rst_n(rst_n),
    .run((state == ST_WRITE) || (state == ST_READ)),
    .phase(blink)
  );

  always_comb begin
    unique case (state)
      ST_HELD:           led = LED_HELD;
      ST_WRITE, ST_READ: led = {blink, blink, 1'b0};
      ST_PASS:           led = LED_PASS;
      ST_FAIL:           led = LED_FAIL;
      default:           led = LED_OFF;
    endcase
  end
endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_n,
  input logic              mem_ready,
  input logic              mem_we,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [2:0]        led
);
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_rd})); // R11

  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (led == 3'b111) |-> (!mem_we && !mem_rd)); // R2

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !mem_ready && start_n && $past(start_n))
      |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata))); // R5

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready && start_n && $past(start_n))
      |=> (mem_rd && $stable(mem_addr))); // R5

  AST_RUN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_rd) |-> (!led[0] && (led[1] == led[2]))); // R7

  AST_PASS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (led == 3'b010 && start_n && $past(start_n)) |=> (led == 3'b010)); // R8

  AST_FAIL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (led == 3'b100 && start_n && $past(start_n)) |=> (led == 3'b100)); // R9
endmodule

bind mem_selftest_top mst_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_bind_i (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .led(led)
);

// File: tb/mem_selftest_top_tb_top.sv
`timescale 1ns/1ps
module mem_selftest_top_tb_top;
  localparam int          AW    = 5;
  localparam int          DEPTH = 1 << AW;
  localparam int          DIV   = 16;
  localparam logic [31:0] SEED  = 32'h5EED_0001;
  localparam logic [31:0] MASK  = 32'hA300_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1;
  logic mem_ready = 1'b0;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic mem_we, mem_rd;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [2:0] led;

  always #2.5 clk = ~clk;

  mem_selftest_top #(.ADDR_W(AW), .DATA_W(32), .SEED(SEED), .MASK(MASK),
                     .BLINK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .led(led)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  function automatic logic [31:0] seq_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? MASK : 32'h0);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and monitor state
  logic [31:0] mem [DEPTH];
  int  rdy_mode = 0;                 // 0 always, 1 random, 2 never
  bit  fault_en = 0, spurious = 0, hold_en = 0, held_settled = 0;
  int  fault_addr = 0;
  int  wr_cnt = 0, rd_cnt = 0, wr_err = 0, rd_err = 0, early_rd = 0;
  int  hold_err = 0, held_err = 0, blink_err = 0, toggles = 0;
  logic [31:0] exp_w = SEED;
  bit  p0_v = 0, p1_v = 0;
  logic [31:0] p0_d = '0, p1_d = '0;
  bit  prev_req = 0, prev_rdy = 0, prev_we = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [31:0] prev_data = '0;
  bit  arm = 0, running = 0, have_tog = 0, last_l1 = 0;
  int  last_tog = 0;

  always @(negedge clk) begin
    bit r;
    cyc++;
    if (rst_n) begin
      if (hold_en && prev_req && !prev_rdy &&
          ((mem_we != prev_we) || (!mem_we && !mem_rd) || mem_addr != prev_addr ||
           (mem_we && mem_wdata != prev_data)))
        hold_err++;
      if (held_settled && (mem_we || mem_rd)) held_err++;
      case (rdy_mode)
        0:       r = 1'b1;
        1:       r = 1'($urandom % 2);
        default: r = 1'b0;
      endcase
      mem_ready = r;
      if (mem_we && r) begin
        if (mem_addr != AW'(wr_cnt) || mem_wdata != exp_w) wr_err++;
        mem[mem_addr] = mem_wdata;
        exp_w = seq_next(exp_w);
        wr_cnt++;
      end
      if (mem_rd && r) begin
        if (wr_cnt != DEPTH) early_rd++;
        if (mem_addr != AW'(rd_cnt)) rd_err++;
        rd_cnt++;
      end
      mem_rvalid = p1_v; mem_rdata = p1_d;
      p1_v = p0_v; p1_d = p0_d;
      p0_v = mem_rd && r;
      p0_d = mem[mem_addr] ^ ((fault_en && int'(mem_addr) == fault_addr) ? 32'h1 : 32'h0);
      if (!mem_rvalid && spurious && mem_we) begin
        mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF;
      end
      prev_req = mem_we || mem_rd; prev_rdy = r; prev_we = mem_we;
      prev_addr = mem_addr; prev_data = mem_wdata;
      if (arm && led != 3'b111) begin
        arm = 0; running = 1; have_tog = 0; last_l1 = 0;
      end
      if (running) begin
        if (led == 3'b010 || led == 3'b100) running = 0;
        else begin
          if (led[0] || led[1] != led[2]) blink_err++;
          if (led[1] != last_l1) begin
            if (have_tog && (cyc - last_tog) != DIV) blink_err++;
            have_tog = 1; last_tog = cyc; toggles++;
          end
          last_l1 = led[1];
        end
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic begin_pass();
    hold_en = 0; running = 0; arm = 0;
    start_n = 1'b0;
    wait_n(4);
    held_settled = 1;
    wait_n(3);
    check(led == 3'b111, "R2", "leds while button held", 32'(led), 32'h7);
    held_settled = 0;
    start_n = 1'b1;
    wr_cnt = 0; rd_cnt = 0; wr_err = 0; rd_err = 0; early_rd = 0;
    hold_err = 0; blink_err = 0; toggles = 0; exp_w = SEED;
    arm = 1;
    wait_n(1);
    hold_en = 1;
  endtask

  task automatic finish_pass(input bit expect_pass, input string tag);
    int guard = 0;
    while (!((led == 3'b010 || led == 3'b100) && !arm && !running) && guard < 8000) begin
      wait_n(1); guard++;
    end
    check(guard < 8000, "R8", {tag, " pass completes"}, 32'(guard), 32'd8000);
    check(wr_cnt == DEPTH && wr_err == 0, "R3", {tag, " write sweep and data"},
          32'(wr_err), 32'd0);
    check(early_rd == 0 && rd_err == 0 && rd_cnt == DEPTH, "R4",
          {tag, " read ordering"}, 32'(rd_cnt), 32'(DEPTH));
    check(hold_err == 0, "R5", {tag, " stalled request held"}, 32'(hold_err), 32'd0);
    check(held_err == 0, "R2", {tag, " quiet while held"}, 32'(held_err), 32'd0);
    check(blink_err == 0 && toggles > 0, "R7", {tag, " blink pattern"},
          32'(blink_err), 32'd0);
    if (expect_pass)
      check(led == 3'b010, "R8", {tag, " pass leds"}, 32'(led), 32'h2);
    else
      check(led == 3'b100, "R9", {tag, " fail leds"}, 32'(led), 32'h4);
    wait_n(40);
    check(led == (expect_pass ? 3'b010 : 3'b100), expect_pass ? "R8" : "R9",
          {tag, " result steady"}, 32'(led), expect_pass ? 32'h2 : 32'h4);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    wait_n(5);
    check(led == 3'b000 && !mem_we && !mem_rd, "R1", "reset state",
          {27'd0, mem_we, mem_rd, led}, 32'h0);
    rst_n = 1'b1;
    wait_n(3);
    check(led == 3'b000 && !mem_we && !mem_rd, "R1", "idle after reset",
          {27'd0, mem_we, mem_rd, led}, 32'h0);

    // directed: always-ready memory
    rdy_mode = 0; begin_pass(); finish_pass(1'b1, "ready-always");

    // random back-pressure
    rdy_mode = 1; begin_pass(); finish_pass(1'b1, "ready-random");

    // corrupted last word
    rdy_mode = 1; fault_en = 1; fault_addr = DEPTH - 1;
    begin_pass(); finish_pass(1'b0, "fault-last R6");

    // corrupted first word, later words good: sticky R9
    fault_addr = 0;
    begin_pass(); finish_pass(1'b0, "fault-first sticky");

    // clean pass after failure clears the flag R10
    fault_en = 0;
    begin_pass(); finish_pass(1'b1, "after-fail R10");

    // abort mid-write R10 / R2
    rdy_mode = 1;
    begin_pass();
    wait_n(10);
    begin_pass();
    finish_pass(1'b1, "after-abort R10");

    // long stall during writes R5
    rdy_mode = 0;
    begin_pass();
    wait_n(8);
    rdy_mode = 2;
    wait_n(2);
    begin
      int snap;
      snap = wr_cnt;
      wait_n(20);
      check(wr_cnt == snap && mem_we, "R5", "no transfer while ready low",
            32'(wr_cnt), 32'(snap));
    end
    rdy_mode = 0;
    finish_pass(1'b1, "long-stall");

    // stray read-valid during write phase R6
    rdy_mode = 1; spurious = 1;
    begin_pass(); finish_pass(1'b1, "stray-rvalid R6");
    spurious = 0;

    // exclusivity of requests observed over a further random pass R11
    begin_pass();
    begin
      int both = 0;
      for (int i = 0; i < 60; i++) begin
        wait_n(1);
        if (mem_we && mem_rd) both++;
      end
      check(both == 0, "R11", "write and read never together", 32'(both), 32'd0);
    end
    finish_pass(1'b1, "exclusive");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule